// File: doc/BRIEF.md
# Performance Monitor Counter Unit

A per-core event monitor with one cycle counter and four event counters, all
programmed over a small register bus. Software picks, for each event counter, a
7-bit event code that selects one line of an incoming event vector. A counter
advances only when the global run bit, its own enable bit and, for event
counters, the selected event line are all high. The cycle counter can advance
on every clock or on every 64th counted clock. It can also be frozen while a
debug-active input is high.

Enables, interrupt enables and overflow flags all use one compact bit layout:
four event slots in the low nibble and the cycle counter in the top bit.
Enables have a separate set register and clear register, and each accepts only
ones. Overflow flags are cleared by writing ones. The event-select and
event-count registers are reached indirectly through a counter-select register.
The `irq` output is a level signal. It stays high while any flagged counter has
its interrupt enabled. To get an interrupt after N events, software preloads a
counter with the two's complement of N.

Reads are registered: `bus_rdata` holds the value addressed by the cycle in
which `bus_rd` was high, starting one clock later. Word addresses: 0 control,
1 enable-set, 2 enable-clear, 3 interrupt-enable-set, 4 overflow flags,
5 counter select, 6 event select (indirect), 7 event count (indirect),
8 cycle count.

Top module: `pmu_unit`

## Requirements
- R1: After reset the control, enable, interrupt-enable and overflow registers and all counters read zero, and `irq` is low.
- R2: Control register (address 0) bits: 0 run, 1 clear event counters, 2 clear cycle counter, 3 divide cycle count by 64, 4 trace request, 5 freeze cycle counter during debug. Bits 0, 3, 4 and 5 are stored and read back. Bits 1 and 2 act for the write cycle only and read back as zero. Bits above 5 are ignored.
- R3: Enable layout: bits 0 to 3 are event counters 0 to 3 and bit 31 is the cycle counter. Other bits are ignored. A one written to address 1 sets the enable, and a one written to address 2 clears it. A zero written to either register leaves the enable unchanged. Both addresses read back the current enables.
- R4: An event counter advances by one on each clock in which the run bit, its enable and `evt_in[code]` are all high. A code at or above the event vector width never counts.
- R5: With bit 3 clear the cycle counter advances on every clock in which run and its enable are set. With bit 3 set it advances on the 64th, 128th and later such clocks, counted from the last cycle-counter clear.
- R6: While bit 5 is set and `dbg_active` is high, the cycle counter holds its value.
- R7: Writing bit 1 zeroes every event counter and leaves the cycle counter alone. Writing bit 2 zeroes the cycle counter and leaves the event counters alone.
- R8: A counter that wraps from all ones to zero sets its overflow flag (address 4, same layout as R3) on that clock. The flag stays set until a one is written to its bit.
- R9: `irq` is high exactly while some overflow flag and its interrupt enable (address 3, a set-only register with the R3 layout) are both set.
- R10: The select register (address 5, 5 bits) chooses event counter 0 to 3 for addresses 6 and 7. A select value of 4 or more makes those addresses read zero and ignore writes.
- R11: A counter preloaded with the two's complement of N raises its overflow flag after exactly N increments, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` one clock later |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | EVT_W | Event lines, one per event code |
| dbg_active | input | 1 | Debug-active indication |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the unit with a 16-line event vector, 32-bit counters and the 64-clock prescale divider. The narrow event vector lets an event code of 20 show the out-of-range case. The full counter width together with preloading makes the exact wrap and flag timing of R11 reachable within a few clocks. Keeping the real divider of 64 shows the prescaled count landing on exactly the 64th and 128th enabled clocks.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 4;
  localparam int NUM_EV  = 4;
  localparam int NSLOT   = NUM_EV + 1;
  localparam int CYC_IDX = NUM_EV;
  localparam int SEL_W   = 5;
  localparam int CODE_W  = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_EN_SET = 4'd1,
    A_EN_CLR = 4'd2,
    A_IE_SET = 4'd3,
    A_OVF    = 4'd4,
    A_SEL    = 4'd5,
    A_EVSEL  = 4'd6,
    A_EVCNT  = 4'd7,
    A_CYC    = 4'd8
  } reg_addr_e;

  // bus word -> slot vector: low nibble are event slots, top bit is the cycle slot
  function automatic logic [NSLOT-1:0] bus_to_slots(input logic [BUS_W-1:0] w);
    return {w[BUS_W-1], w[NUM_EV-1:0]};
  endfunction

  function automatic logic [BUS_W-1:0] slots_to_bus(input logic [NSLOT-1:0] s);
    return {s[CYC_IDX], {(BUS_W-NUM_EV-1){1'b0}}, s[NUM_EV-1:0]};
  endfunction
endpackage

// File: rtl/pmu_cnt.sv
module pmu_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (clr)  value <= '0;
    else if (load) value <= load_val;
    else if (inc)  value <= value + 1'b1;
  end

  assign wrap = inc && !clr && !load && (&value);

  // R11: a wrap leaves the counter at zero
  a_r11_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (value == '0));
endmodule

// File: rtl/pmu_presc.sv
module pmu_presc #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt;

  assign tick = adv && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (adv)  cnt <= tick ? '0 : cnt + 1'b1;
  end

  // R5: prescaled ticks are never back to back
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pmu_unit.sv
module pmu_unit #(
  parameter int CNT_W     = 32,
  parameter int EVT_W     = 32,
  parameter int PRESC_DIV = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic [pmu_pkg::ADDR_W-1:0] bus_addr,
  input  logic [pmu_pkg::BUS_W-1:0] bus_wdata,
  output logic [pmu_pkg::BUS_W-1:0] bus_rdata,
  input  logic [EVT_W-1:0]          evt_in,
  input  logic                      dbg_active,
  output logic                      irq
);
  import pmu_pkg::*;

  localparam int EXT_W = 1 << CODE_W;

  // control state
  logic glob_en, div_mode, trace_req, dbg_stop;
  logic [NSLOT-1:0] en_q, ie_q, ovf_q;
  logic [SEL_W-1:0] sel_q;

  // decoded bus events, named for the assertions
  logic wr_ctrl, wr_en_set, wr_en_clr, wr_ie_set, wr_ovf, wr_sel, wr_evsel, wr_evcnt, wr_cyc;
  logic sel_ok, ev_clr, cyc_clr;
  logic [NSLOT-1:0] wd_slots;

  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_en_set = bus_wr && (bus_addr == A_EN_SET);
  assign wr_en_clr = bus_wr && (bus_addr == A_EN_CLR);
  assign wr_ie_set = bus_wr && (bus_addr == A_IE_SET);
  assign wr_ovf    = bus_wr && (bus_addr == A_OVF);
  assign wr_sel    = bus_wr && (bus_addr == A_SEL);
  assign wr_evsel  = bus_wr && (bus_addr == A_EVSEL);
  assign wr_evcnt  = bus_wr && (bus_addr == A_EVCNT);
  assign wr_cyc    = bus_wr && (bus_addr == A_CYC);
  assign wd_slots  = bus_to_slots(bus_wdata);
  assign sel_ok    = (sel_q < SEL_W'(NUM_EV));
  assign ev_clr    = wr_ctrl && bus_wdata[1];
  assign cyc_clr   = wr_ctrl && bus_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0; div_mode <= 1'b0; trace_req <= 1'b0; dbg_stop <= 1'b0;
      en_q <= '0; ie_q <= '0; sel_q <= '0;
    end else begin
      if (wr_ctrl) begin
        glob_en   <= bus_wdata[0];
        div_mode  <= bus_wdata[3];
        trace_req <= bus_wdata[4];
        dbg_stop  <= bus_wdata[5];
      end
      if (wr_en_set) en_q <= en_q | wd_slots;
      if (wr_en_clr) en_q <= en_q & ~wd_slots;
      if (wr_ie_set) ie_q <= ie_q | wd_slots;
      if (wr_sel)    sel_q <= bus_wdata[SEL_W-1:0];
    end
  end

  // event counter slots
  logic [NSLOT-1:0] wrap_v;
  logic [CNT_W-1:0] ev_val [NUM_EV];
  logic [CODE_W-1:0] code_q [NUM_EV];
  logic [EXT_W-1:0] evt_ext;
  assign evt_ext = EXT_W'(evt_in);

  function automatic logic evt_hit(input logic [CODE_W-1:0] code,
                                   input logic [EXT_W-1:0] lines);
    return (int'(code) < EVT_W) && lines[code];
  endfunction

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    logic picked, inc;
    assign picked = sel_ok && (sel_q == SEL_W'(i));
    assign inc    = glob_en && en_q[i] && evt_hit(code_q[i], evt_ext);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   code_q[i] <= '0;
      else if (wr_evsel && picked)  code_q[i] <= bus_wdata[CODE_W-1:0];
    end

    pmu_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(ev_clr), .load(wr_evcnt && picked),
      .load_val(bus_wdata[CNT_W-1:0]), .inc(inc), .value(ev_val[i]), .wrap(wrap_v[i])
    );

    // R4: with the run bit low and no bus access, an event counter holds
    a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en && !wr_evcnt && !ev_clr) |=> $stable(ev_val[i]));
  end

  // cycle counter with optional prescale
  logic cyc_run, cyc_tick, cyc_inc;
  logic [CNT_W-1:0] cyc_val;
  assign cyc_run = glob_en && en_q[CYC_IDX] && !(dbg_stop && dbg_active);

  pmu_presc #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(cyc_clr), .adv(cyc_run && div_mode), .tick(cyc_tick)
  );

  assign cyc_inc = cyc_run && (!div_mode || cyc_tick);

  pmu_cnt #(.W(CNT_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(cyc_clr), .load(wr_cyc),
    .load_val(bus_wdata[CNT_W-1:0]), .inc(cyc_inc), .value(cyc_val), .wrap(wrap_v[CYC_IDX])
  );

  // overflow flags: a new wrap wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= (ovf_q & ~(wr_ovf ? wd_slots : '0)) | wrap_v;
  end

  assign irq = |(ovf_q & ie_q);

  // registered read port
  logic [BUS_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL:   rd_mux = {{(BUS_W-6){1'b0}}, dbg_stop, trace_req, div_mode, 2'b00, glob_en};
      A_EN_SET,
      A_EN_CLR: rd_mux = slots_to_bus(en_q);
      A_IE_SET: rd_mux = slots_to_bus(ie_q);
      A_OVF:    rd_mux = slots_to_bus(ovf_q);
      A_SEL:    rd_mux = BUS_W'(sel_q);
      A_EVSEL:  rd_mux = sel_ok ? BUS_W'(code_q[sel_q[1:0]]) : '0;
      A_EVCNT:  rd_mux = sel_ok ? BUS_W'(ev_val[sel_q[1:0]]) : '0;
      A_CYC:    rd_mux = BUS_W'(cyc_val);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R8: a flag is only dropped by a clearing write
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ovf |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R3: bits written to the set register are enabled afterwards
  a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_set |=> ((en_q & bus_to_slots($past(bus_wdata))) == bus_to_slots($past(bus_wdata))));

  // R6: frozen cycle counter during debug
  a_r6_debug_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_stop && dbg_active && !wr_cyc && !cyc_clr) |=> $stable(cyc_val));

  // R10: indirect count reads with an out-of-range select give zero
  a_r10_indirect_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == A_EVCNT) && !sel_ok) |=> (bus_rdata == '0));

  // R9: no pending enabled flag, no interrupt; a rising irq needs a flag just set
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ovf_q != $past(ovf_q) || ie_q != $past(ie_q)));
endmodule

// File: tb/pmu_unit_bench.sv
module pmu_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EVT_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [EVT_W-1:0] evt_in = '0;
  logic        dbg_active = 1'b0;
  logic        irq;

  int n_checks = 0, n_fails = 0;
  bit done = 1'b0;
  logic [31:0] q_exp [$];
  string       q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmu_unit #(.CNT_W(32), .EVT_W(EVT_W), .PRESC_DIV(64)) u_pmu_unit (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .dbg_active(dbg_active), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // every bus task starts just after a falling edge and uses one rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    q_exp.push_back(exp); q_tag.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // run for exactly n enabled clocks with the given extra control bits
  task automatic run(input int n, input logic [31:0] extra);
    wr(4'd0, extra | 32'h1);
    repeat (n - 1) @(negedge clk);
    wr(4'd0, extra);
  endtask

  // monitor: pops the scoreboard once the registered read data is valid
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (q_exp.size() == 0) begin
          n_checks++; n_fails++;
          $display("FAIL scoreboard: read with no expectation");
        end else begin
          check(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, 32'h0, "R1 ctrl");
    rd(4'd1, 32'h0, "R1 enables");
    rd(4'd3, 32'h0, "R1 irq enables");
    rd(4'd4, 32'h0, "R1 flags");
    rd(4'd8, 32'h0, "R1 cycle count");
    check("R1 irq", 32'(irq), 32'h0);

    // R2 control bits
    wr(4'd0, 32'h0000_003E);
    rd(4'd0, 32'h0000_0038, "R2 pulse bits read zero");
    wr(4'd0, 32'hFFFF_FFF9);
    rd(4'd0, 32'h0000_0039, "R2 upper bits ignored");
    wr(4'd0, 32'h0);
    rd(4'd0, 32'h0, "R2 cleared");

    // R3 set / clear enables
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, 32'h8000_000F, "R3 set mask");
    wr(4'd2, 32'h0000_0005);
    rd(4'd2, 32'h8000_000A, "R3 clear ones only");
    wr(4'd1, 32'h0);
    rd(4'd1, 32'h8000_000A, "R3 zero write no effect");
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd1, 32'h0, "R3 clear all");

    // R4 event selection
    wr(4'd5, 32'd0); wr(4'd6, 32'd5);
    wr(4'd5, 32'd1); wr(4'd6, 32'd7);
    wr(4'd5, 32'd2); wr(4'd6, 32'd20);
    rd(4'd6, 32'd20, "R4 event code readback");
    wr(4'd1, 32'h0000_0007);
    evt_in = 16'h0020;
    repeat (4) @(negedge clk);           // run bit low: nothing counts
    run(5, 32'h0);
    wr(4'd5, 32'd0); rd(4'd7, 32'd5, "R4 counter0 line 5");
    wr(4'd5, 32'd1); rd(4'd7, 32'd0, "R4 counter1 line 7 low");
    wr(4'd5, 32'd2); rd(4'd7, 32'd0, "R4 out-of-range code");
    evt_in = 16'h00A0;
    wr(4'd2, 32'h0000_0001);
    run(3, 32'h0);
    wr(4'd5, 32'd0); rd(4'd7, 32'd5, "R4 disabled counter holds");
    wr(4'd5, 32'd1); rd(4'd7, 32'd3, "R4 counter1 line 7 high");
    evt_in = '0;

    // R5 cycle counter, plain and prescaled
    wr(4'd0, 32'h4);
    wr(4'd1, 32'h8000_0000);
    run(10, 32'h0);
    rd(4'd8, 32'd10, "R5 every clock");
    wr(4'd0, 32'hC);
    run(130, 32'h8);
    rd(4'd8, 32'd2, "R5 divide by 64");

    // R6 debug freeze
    wr(4'd0, 32'h4);
    dbg_active = 1'b1;
    run(4, 32'h20);
    rd(4'd8, 32'd0, "R6 frozen in debug");
    dbg_active = 1'b0;
    run(4, 32'h20);
    rd(4'd8, 32'd4, "R6 runs out of debug");

    // R7 independent clears
    wr(4'd0, 32'h2);
    wr(4'd5, 32'd1); rd(4'd7, 32'd0, "R7 event clear");
    rd(4'd8, 32'd4, "R7 cycle kept");
    wr(4'd0, 32'h4);
    rd(4'd8, 32'd0, "R7 cycle clear");

    // R10 indirect access guard
    wr(4'd5, 32'd1); wr(4'd7, 32'h1234);
    rd(4'd7, 32'h1234, "R10 indirect write");
    wr(4'd5, 32'd4); wr(4'd7, 32'h55); wr(4'd6, 32'd9);
    rd(4'd7, 32'h0, "R10 select 4 count reads zero");
    rd(4'd6, 32'h0, "R10 select 4 code reads zero");
    wr(4'd5, 32'd1);
    rd(4'd7, 32'h1234, "R10 write ignored count");
    rd(4'd6, 32'd7, "R10 write ignored code");

    // R11 / R8 / R9 event counter overflow
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd5, 32'd0); wr(4'd7, 32'hFFFF_FFFD);
    wr(4'd1, 32'h1);
    evt_in = 16'h0020;
    run(2, 32'h0);
    rd(4'd4, 32'h0, "R11 no flag before N");
    rd(4'd7, 32'hFFFF_FFFF, "R11 count before N");
    run(1, 32'h0);
    rd(4'd4, 32'h1, "R11 flag after N");
    rd(4'd7, 32'h0, "R8 wrapped to zero");
    check("R9 irq masked", 32'(irq), 32'h0);
    wr(4'd3, 32'h1);
    check("R9 irq raised", 32'(irq), 32'h1);
    wr(4'd4, 32'h8000_0000);
    check("R8 other bit clear keeps irq", 32'(irq), 32'h1);
    rd(4'd4, 32'h1, "R8 flag kept");
    wr(4'd4, 32'h1);
    check("R9 irq dropped", 32'(irq), 32'h0);
    rd(4'd4, 32'h0, "R8 flag cleared");

    // R8 / R9 cycle counter overflow
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd1, 32'h8000_0000);
    wr(4'd3, 32'h8000_0000);
    run(1, 32'h0);
    rd(4'd4, 32'h8000_0000, "R8 cycle flag");
    check("R9 irq from cycle", 32'(irq), 32'h1);
    wr(4'd4, 32'hFFFF_FFFF);
    check("R9 irq after clear", 32'(irq), 32'h0);
    evt_in = '0;

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule